// File: doc/BRIEF.md
# Audio Interface Control Register File

This block is the control register file of a multichannel audio interface. A host reaches it over a simple register bus with a byte-offset address, 32-bit data, a write strobe and a read strobe. Every register is one aligned 32-bit quadlet.

The block holds a sample-rate register and sorts the written rate into a speed band of 1x, 2x or 4x. Rates outside the supported range raise an invalid flag instead. Three configuration words are committed together, and only by a complete burst of three writes. On commit, the block decodes the clock-synchronisation source and the master/autosync mode from the third word. A host-presence LED is lit from reset and goes out for good after the first valid configuration.

The block also keeps one mute flag per audio channel and a streaming-active state. Stopping the stream mutes every channel. The first quadlet of the mute window has a second use: a read there returns a live device status word, not a stored mute value.

Top module: `acr_regs`

## Requirements
- R1: After reset the rate register reads 44100 (0x0000AC44), rate_mult is 0 (1x), rate_invalid and sync_err are 0, sync_src is 000, clk_autosync is 0, host_led is 1, every mute flag is 1, stream_active is 0 and the three configuration words read 0.
- R2: A write to offset 0x00 stores the rate in Hz, which reads back from 0x00. If the rate is valid, rate_mult becomes 2 (4x) for a rate above 112000, 1 (2x) for a rate above 56000 up to 112000, and 0 (1x) otherwise.
- R3: A rate below 30000 or above 210000 sets rate_invalid and leaves rate_mult unchanged. A valid rate write clears rate_invalid.
- R4: Configuration words live at 0x14, 0x18 and 0x1C. All three change together, and only when three consecutive write transactions go to 0x14, 0x18 and 0x1C in that order. Any other write in between, or any out-of-order write, leaves all three unchanged.
- R5: On commit, sync_src takes bits 12:10 of the third word when the code is defined: 000, 001, 011, 100 or 101. clk_autosync takes bit 0 of the third word (0 master, 1 autosync).
- R6: On commit with an undefined sync code (010, 110 or 111), sync_err goes to 1 and sync_src keeps its previous value. A commit with a defined code clears sync_err.
- R7: host_led goes to 0 after the first committed burst whose third word has bit 31 set, and it never returns to 1. A commit with bit 31 clear leaves the LED unchanged.
- R8: Writing offset 0x40 + 4*i (i from 0 to 27) sets mute flag i to bit 0 of the data. The flag appears on mute_flags[i].
- R9: A read of 0x40 returns dev_status. A read of any other mute offset returns {31'b0, mute flag i}.
- R10: A write to 0x24 with bit 0 = 1 sets stream_active. A write with bit 0 = 0 clears stream_active and forces all mute flags to 1. Reading 0x24 returns {31'b0, stream_active}.
- R11: Read data appears on rdata in the cycle after rd_en is sampled. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the quadlet |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| dev_status | input | 32 | Live status word returned at the mute window base |
| rate_mult | output | 2 | Speed band: 0 = 1x, 1 = 2x, 2 = 4x |
| rate_invalid | output | 1 | Last rate write was out of range |
| sync_src | output | 3 | Decoded synchronisation source code |
| sync_err | output | 1 | Last commit carried an undefined sync code |
| clk_autosync | output | 1 | 1 = autosync, 0 = master |
| host_led | output | 1 | Host-presence LED drive, lit from reset |
| mute_flags | output | 28 | Per-channel mute, 1 = muted |
| stream_active | output | 1 | Streaming state |

## Verification
A broken burst tracker is visible at the configuration words. An out-of-order write would commit a half-formed configuration, and this shows on the sync_src, clk_autosync and host_led pins, and on readback, one cycle after the third write. A wrong classifier boundary shows at rate_mult the cycle after the rate write, so the bench writes the exact values 30000, 56000, 56001, 112000, 210000 and 210001. Stale mute state after a stop, or a mute window that returns stored bits at its base, shows on mute_flags and rdata on the next cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MULT_1X = 2'd0,
        MULT_2X = 2'd1,
        MULT_4X = 2'd2
    } mult_e;

    typedef struct packed {
        logic  ok;
        mult_e band;
    } rate_class_t;

    localparam logic [31:0] RATE_MIN   = 32'd30000;
    localparam logic [31:0] RATE_MAX   = 32'd210000;
    localparam logic [31:0] RATE_2X_TH = 32'd56000;
    localparam logic [31:0] RATE_4X_TH = 32'd112000;
    localparam logic [31:0] RATE_RESET = 32'd44100;

    function automatic rate_class_t classify_rate(input logic [31:0] hz);
        rate_class_t r;
        r.ok = (hz >= RATE_MIN) && (hz <= RATE_MAX);
        if (hz > RATE_4X_TH)      r.band = MULT_4X;
        else if (hz > RATE_2X_TH) r.band = MULT_2X;
        else                      r.band = MULT_1X;
        return r;
    endfunction

    function automatic logic sync_code_known(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b001) || (code == 3'b011) ||
               (code == 3'b100) || (code == 3'b101);
    endfunction

endpackage

// File: rtl/acr_rate_unit.sv
module acr_rate_unit
    import acr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic [31:0] wdata,
    output logic [31:0] rate_q,
    output mult_e       mult_q,
    output logic        invalid_q
);
    rate_class_t cls;
    assign cls = classify_rate(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q    <= RATE_RESET;
            mult_q    <= MULT_1X;
            invalid_q <= 1'b0;
        end else if (sel) begin
            rate_q    <= wdata;
            invalid_q <= !cls.ok;
            if (cls.ok) mult_q <= cls.band;
        end
    end

    // R3
    bad_rate_holds_mult_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !cls.ok) |=> ($stable(mult_q) && invalid_q));

    // R2
    mult_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mult_q != 2'd3);
endmodule

// File: rtl/acr_cfg_unit.sv
module acr_cfg_unit
    import acr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        sel_w0,
    input  logic        sel_w1,
    input  logic        sel_w2,
    input  logic [31:0] wdata,
    output logic [31:0] cfg0_q,
    output logic [31:0] cfg1_q,
    output logic [31:0] cfg2_q,
    output logic [2:0]  sync_q,
    output logic        sync_err_q,
    output logic        autosync_q,
    output logic        led_q
);
    localparam int SYNC_LO = 10;
    localparam int VALID_BIT = 31;

    logic [1:0]  step_q;
    logic [31:0] hold0_q, hold1_q;
    logic        commit;
    logic [2:0]  code;

    assign commit = wr_en && sel_w2 && (step_q == 2'd2);
    assign code   = wdata[SYNC_LO +: 3];

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= 2'd0;
            hold0_q <= '0;
            hold1_q <= '0;
        end else if (wr_en) begin
            if (sel_w0) begin
                hold0_q <= wdata;
                step_q  <= 2'd1;
            end else if (sel_w1 && step_q == 2'd1) begin
                hold1_q <= wdata;
                step_q  <= 2'd2;
            end else begin
                step_q  <= 2'd0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg0_q     <= '0;
            cfg1_q     <= '0;
            cfg2_q     <= '0;
            sync_q     <= 3'b000;
            sync_err_q <= 1'b0;
            autosync_q <= 1'b0;
            led_q      <= 1'b1;
        end else if (commit) begin
            cfg0_q     <= hold0_q;
            cfg1_q     <= hold1_q;
            cfg2_q     <= wdata;
            autosync_q <= wdata[0];
            if (sync_code_known(code)) begin
                sync_q     <= code;
                sync_err_q <= 1'b0;
            end else begin
                sync_err_q <= 1'b1;
            end
            if (wdata[VALID_BIT]) led_q <= 1'b0;
        end
    end

    // R4
    cfg_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(cfg0_q) && $stable(cfg1_q) && $stable(cfg2_q)));

    // R6
    bad_sync_keeps_src_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !sync_code_known(code)) |=> ($stable(sync_q) && sync_err_q));

    // R7
    led_never_relit_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(led_q));
endmodule

// File: rtl/acr_mute_unit.sv
module acr_mute_unit #(
    parameter int NUM_CH    = 28,
    parameter int ADDR_W    = 8,
    parameter int MUTE_BASE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_stream,
    input  logic              wbit,
    output logic [NUM_CH-1:0] mute_q,
    output logic              active_q
);
    logic stop;
    assign stop = wr_en && sel_stream && !wbit;

    always_ff @(posedge clk) begin
        if (rst)                      active_q <= 1'b0;
        else if (wr_en && sel_stream) active_q <= wbit;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(MUTE_BASE + 4 * i);
        always_ff @(posedge clk) begin
            if (rst || stop)                    mute_q[i] <= 1'b1;
            else if (wr_en && addr == CH_ADDR)  mute_q[i] <= wbit;
        end
    end

    // R10
    stop_mutes_all_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> ((&mute_q) && !active_q));
endmodule

// File: rtl/acr_regs.sv
module acr_regs
    import acr_pkg::*;
#(
    parameter int NUM_CH    = 28,
    parameter int ADDR_W    = 8,
    parameter int MUTE_BASE = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [31:0]       dev_status,
    output logic [1:0]        rate_mult,
    output logic              rate_invalid,
    output logic [2:0]        sync_src,
    output logic              sync_err,
    output logic              clk_autosync,
    output logic              host_led,
    output logic [NUM_CH-1:0] mute_flags,
    output logic              stream_active
);
    localparam logic [ADDR_W-1:0] A_RATE   = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_CFG0   = ADDR_W'('h14);
    localparam logic [ADDR_W-1:0] A_CFG1   = ADDR_W'('h18);
    localparam logic [ADDR_W-1:0] A_CFG2   = ADDR_W'('h1C);
    localparam logic [ADDR_W-1:0] A_STREAM = ADDR_W'('h24);
    localparam logic [ADDR_W-1:0] A_MBASE  = ADDR_W'(MUTE_BASE);
    localparam logic [ADDR_W-1:0] A_MEND   = ADDR_W'(MUTE_BASE + 4 * NUM_CH);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [31:0] rate_q, cfg0, cfg1, cfg2;
    mult_e       mult;

    acr_rate_unit u_rate (
        .clk(clk), .rst(rst), .sel(wr_en && addr == A_RATE), .wdata(wdata),
        .rate_q(rate_q), .mult_q(mult), .invalid_q(rate_invalid)
    );

    acr_cfg_unit u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .sel_w0(addr == A_CFG0), .sel_w1(addr == A_CFG1), .sel_w2(addr == A_CFG2),
        .wdata(wdata), .cfg0_q(cfg0), .cfg1_q(cfg1), .cfg2_q(cfg2),
        .sync_q(sync_src), .sync_err_q(sync_err), .autosync_q(clk_autosync),
        .led_q(host_led)
    );

    acr_mute_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MUTE_BASE(MUTE_BASE)) u_mute (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .sel_stream(addr == A_STREAM), .wbit(wdata[0]),
        .mute_q(mute_flags), .active_q(stream_active)
    );

    assign rate_mult = mult;

    logic              in_mute;
    logic [ADDR_W-1:0] moff;
    logic [IDX_W-1:0]  midx;
    logic [31:0]       rd_next;

    assign in_mute = (addr >= A_MBASE) && (addr < A_MEND) && (addr[1:0] == 2'b00);
    assign moff    = addr - A_MBASE;
    assign midx    = IDX_W'(moff >> 2);

    always_comb begin
        rd_next = '0;
        if (addr == A_RATE)        rd_next = rate_q;
        else if (addr == A_CFG0)   rd_next = cfg0;
        else if (addr == A_CFG1)   rd_next = cfg1;
        else if (addr == A_CFG2)   rd_next = cfg2;
        else if (addr == A_STREAM) rd_next = {31'b0, stream_active};
        else if (addr == A_MBASE)  rd_next = dev_status;
        else if (in_mute)          rd_next = {31'b0, mute_flags[midx]};
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    // R11
    rdata_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/acr_regs_tb.sv
`timescale 1ns/1ps
module acr_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] dev_status = 32'hA5C3_0F12;
    logic [1:0]  rate_mult;
    logic        rate_invalid, sync_err, clk_autosync, host_led, stream_active;
    logic [2:0]  sync_src;
    logic [27:0] mute_flags;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    acr_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dev_status(dev_status),
        .rate_mult(rate_mult), .rate_invalid(rate_invalid), .sync_src(sync_src),
        .sync_err(sync_err), .clk_autosync(clk_autosync), .host_led(host_led),
        .mute_flags(mute_flags), .stream_active(stream_active)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard one cycle after each sampled read
    always begin
        @(posedge clk);
        #1;
        if (rd_en && !rst) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R11: read with empty scoreboard actual %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic burst(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        wr(8'h14, w0); wr(8'h18, w1); wr(8'h1C, w2);
    endtask

    task automatic rate_case(input logic [31:0] hz, input logic [1:0] em, input logic ei, input string tag);
        wr(8'h00, hz);
        check({tag, " mult"}, 32'(rate_mult), 32'(em));
        check({tag, " invalid"}, 32'(rate_invalid), 32'(ei));
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 led", 32'(host_led), 1);
        check("R1 mult", 32'(rate_mult), 0);
        check("R1 invalid", 32'(rate_invalid), 0);
        check("R1 sync", 32'(sync_src), 0);
        check("R1 err", 32'(sync_err), 0);
        check("R1 autosync", 32'(clk_autosync), 0);
        check("R1 mutes", 32'(mute_flags), 32'h0FFF_FFFF);
        check("R1 stream", 32'(stream_active), 0);
        rd(8'h00, 32'd44100, "R1 rate reg");
        rd(8'h1C, 32'd0, "R1 cfg word");

        // R2 bands and boundaries
        rate_case(32'd96000, 2'd1, 1'b0, "R2 96000");
        rate_case(32'd192000, 2'd2, 1'b0, "R2 192000");
        rate_case(32'd112000, 2'd1, 1'b0, "R2 112000");
        rate_case(32'd112001, 2'd2, 1'b0, "R2 112001");
        rate_case(32'd56000, 2'd0, 1'b0, "R2 56000");
        rate_case(32'd56001, 2'd1, 1'b0, "R2 56001");
        rate_case(32'd30000, 2'd0, 1'b0, "R2 30000");
        rd(8'h00, 32'd30000, "R2 readback");
        // R3 invalid keeps multiplier
        rate_case(32'd210000, 2'd2, 1'b0, "R3 210000");
        rate_case(32'd210001, 2'd2, 1'b1, "R3 210001");
        rate_case(32'd29999, 2'd2, 1'b1, "R3 29999");
        rate_case(32'd48000, 2'd0, 1'b0, "R3 recover");

        // R4 incomplete and out-of-order bursts
        wr(8'h14, 32'h1111_1111); wr(8'h18, 32'h2222_2222);
        wr(8'h00, 32'd44100);
        wr(8'h1C, 32'h8000_0C01);
        rd(8'h14, 32'd0, "R4 broken w0");
        rd(8'h1C, 32'd0, "R4 broken w2");
        check("R4 led after broken", 32'(host_led), 1);
        wr(8'h18, 32'h3); wr(8'h14, 32'h4); wr(8'h1C, 32'h8000_0001);
        rd(8'h1C, 32'd0, "R4 out of order");

        // R7 complete burst without valid bit
        burst(32'hA, 32'hB, 32'h0000_1000);
        check("R7 led stays", 32'(host_led), 1);
        check("R5 wordclock", 32'(sync_src), 3'b100);
        rd(8'h14, 32'hA, "R4 w0");
        rd(8'h18, 32'hB, "R4 w1");

        // R5 valid burst, SPDIF, autosync
        burst(32'h5, 32'h6, 32'h8000_0C01);
        check("R7 led off", 32'(host_led), 0);
        check("R5 spdif", 32'(sync_src), 3'b011);
        check("R5 autosync", 32'(clk_autosync), 1);
        rd(8'h1C, 32'h8000_0C01, "R4 w2");

        // R6 undefined code
        burst(32'h0, 32'h0, 32'h8000_1800);
        check("R6 err", 32'(sync_err), 1);
        check("R6 src kept", 32'(sync_src), 3'b011);
        check("R5 master", 32'(clk_autosync), 0);
        burst(32'h0, 32'h0, 32'h0000_1400);
        check("R6 err clear", 32'(sync_err), 0);
        check("R5 timecode", 32'(sync_src), 3'b101);
        check("R7 led stays off", 32'(host_led), 0);

        // R10 start, R8 mute writes, R9 window reads
        wr(8'h24, 32'h1);
        check("R10 active", 32'(stream_active), 1);
        rd(8'h24, 32'h1, "R10 readback");
        for (int i = 0; i < 28; i++) wr(8'(8'h40 + 4 * i), 32'h0);
        wr(8'h54, 32'h1);
        check("R8 flags", 32'(mute_flags), 32'h0000_0020);
        rd(8'h40, 32'hA5C3_0F12, "R9 status");
        dev_status = 32'h0BAD_F00D;
        rd(8'h40, 32'h0BAD_F00D, "R9 status live");
        rd(8'h44, 32'h0, "R9 ch1");
        rd(8'h54, 32'h1, "R9 ch5");
        rd(8'h30, 32'h0, "R11 unmapped");

        // R10 stop
        wr(8'h24, 32'h0);
        check("R10 stopped", 32'(stream_active), 0);
        check("R10 all muted", 32'(mute_flags), 32'h0FFF_FFFF);

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule